// File: doc/BRIEF.md
# Byte Memory DMA Controller

This block copies words between an on-chip memory port and an external byte-wide memory while the processor keeps running. Software first sets up the transfer through a small register write port. It gives the on-chip start address, the external start address as a page plus a 14-bit offset, and a control word that holds the direction, the packing format and the wait-state count. Writing a nonzero word count then launches the transfer.

For every on-chip word the controller makes one, two or three byte accesses, sending the most significant byte first. In the load direction it assembles the word and writes it to on-chip memory in a single cycle. In the store direction it reads the word in a single cycle and then splits it into bytes. The external address runs through a 22-bit space, so the page advances when the offset wraps.

The controller starts a byte access only when the processor's external request is low. It counts words down live and exposes the count as status. When the count reaches zero it raises a one-cycle completion pulse.

Top module: `bytemem_dma`

## Requirements
- R1: After reset the block is idle: busy_o, irq_o, bm_sel_o and mem_req_o are 0 and word_count_o is 0.
- R2: A write to register select 4 (word count) while idle starts a transfer if the value is nonzero, and busy_o is 1 from the next cycle. A zero value has no effect: busy_o stays 0 and no irq_o pulse follows.
- R3: Format field value 00 moves 24-bit program words. Three bytes form one word, the first byte being bits 23:16, and mem_prog_o is 1 on those on-chip accesses.
- R4: Format 01 moves 16-bit data words built from two bytes as {8'h00, first, second}. In store direction bits 15:8 and then bits 7:0 are sent, and mem_prog_o is 0.
- R5: Format 10 moves one byte into bits 15:8 of a data word, and format 11 moves one byte into bits 7:0. All other bits of a loaded word are 0, and a store sends the byte from the same position.
- R6: The external address of each byte access is {page, offset}. The page appears on bm_data_o[23:16] and the offset on bm_addr_o. The 22-bit address rises by one per byte, so the page increments when the offset wraps and the whole space wraps to zero.
- R7: Each byte access holds bm_sel_o high for (wait states + 1) cycles with a stable address. Consecutive accesses are separated by at least one cycle.
- R8: Each on-chip access lasts one cycle (mem_req_o). The on-chip address starts at the programmed value and rises by one per word.
- R9: Control bit 0 selects the direction. 0 loads from byte memory (bm_rd_o, data taken from bm_din_i, the bus bits 15:8). 1 stores to byte memory (bm_wr_o, data on bm_data_o[15:8]).
- R10: A byte access never begins in the cycle after one in which ext_req_i was high.
- R11: word_count_o decrements by one per completed word and never increases during a transfer.
- R12: When the count reaches zero, irq_o is high for exactly one cycle. In that cycle word_count_o is 0 and busy_o is 0.
- R13: Register writes made while busy_o is 1 are ignored. Register selects: 0 on-chip address, 1 external offset, 2 page, 3 control {wait states [5:3], format [2:1], direction [0]}, 4 word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 3 | Register select |
| cfg_wdata_i | input | ADDR_W | Register write data |
| ext_req_i | input | 1 | Processor external-bus request, has priority |
| bm_sel_o | output | 1 | Byte memory select |
| bm_rd_o | output | 1 | Byte memory read |
| bm_wr_o | output | 1 | Byte memory write |
| bm_addr_o | output | ADDR_W | Byte address offset within page |
| bm_data_o | output | 24 | Bus out: page on 23:16, store byte on 15:8 |
| bm_din_i | input | 8 | Byte read from bus bits 15:8 |
| mem_req_o | output | 1 | On-chip memory access |
| mem_we_o | output | 1 | On-chip write (load direction) |
| mem_prog_o | output | 1 | On-chip access targets program memory |
| mem_addr_o | output | IADDR_W | On-chip word address |
| mem_wdata_o | output | 24 | On-chip write data |
| mem_rdata_i | input | 24 | On-chip read data, valid in the access cycle |
| busy_o | output | 1 | Transfer in progress |
| word_count_o | output | ADDR_W | Remaining words |
| irq_o | output | 1 | Completion pulse |

## Verification
The hardest condition to reach is a byte access that is ready but held back by the processor. The bench produces it by driving ext_req_i from a free-running shift-register pattern during several transfers. On every rising edge of bm_sel_o it confirms that the request was low in the cycle before. Two more conditions are only visible when an access crosses a boundary: a page wrap, and a wrap of the whole 22-bit space. The bench places the external start one or two bytes below those boundaries, so the wrap shows up in the addresses it compares. Register writes issued mid-transfer must leave the expected access streams untouched.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
  localparam int BYTE_W = 8;
  localparam int PAGE_W = 8;
  localparam int BUS_W  = PAGE_W + 2 * BYTE_W;
  localparam int WORD_W = 24;

  typedef enum logic [1:0] {
    FMT_W24  = 2'b00,
    FMT_W16  = 2'b01,
    FMT_B_HI = 2'b10,
    FMT_B_LO = 2'b11
  } fmt_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_ARB, ST_BYTE, ST_XFER
  } state_e;

  localparam logic [2:0] SEL_IADDR = 3'd0;
  localparam logic [2:0] SEL_EOFS  = 3'd1;
  localparam logic [2:0] SEL_PAGE  = 3'd2;
  localparam logic [2:0] SEL_CTRL  = 3'd3;
  localparam logic [2:0] SEL_CNT   = 3'd4;

  function automatic logic [1:0] bytes_per_word(fmt_e f);
    case (f)
      FMT_W24: return 2'd3;
      FMT_W16: return 2'd2;
      default: return 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/bmd_cfg_regs.sv
module bmd_cfg_regs import bmd_pkg::*; #(
  parameter int WS_W = 3,
  localparam int CTRL_W = 3 + WS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic              dir_o,
  output fmt_e              fmt_o,
  output logic [WS_W-1:0]   ws_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o <= 1'b0;
      fmt_o <= FMT_W24;
      ws_o  <= '0;
    end else if (we_i) begin
      dir_o <= wdata_i[0];
      fmt_o <= fmt_e'(wdata_i[2:1]);
      ws_o  <= wdata_i[CTRL_W-1:3];
    end
  end
endmodule

// File: rtl/bmd_ext_addr.sv
module bmd_ext_addr import bmd_pkg::*; #(
  parameter int ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ofs_we_i,
  input  logic              page_we_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] ofs_o,
  output logic [PAGE_W-1:0] page_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_o  <= '0;
      page_o <= '0;
    end else begin
      if (ofs_we_i)  ofs_o  <= wdata_i;
      if (page_we_i) page_o <= wdata_i[PAGE_W-1:0];
      // page carries out of the offset
      if (inc_i) {page_o, ofs_o} <= {page_o, ofs_o} + 1'b1;
    end
  end
endmodule

// File: rtl/bmd_word_path.sv
module bmd_word_path import bmd_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  fmt_e              fmt_i,
  input  logic              cap_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              shift_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [1:0]        idx_i,
  output logic [WORD_W-1:0] load_word_o,
  output logic [BYTE_W-1:0] store_byte_o
);
  logic [WORD_W-1:0] acc_q, buf_q, src;
  logic [1:0]        sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      buf_q <= '0;
    end else begin
      if (cap_i)   buf_q <= word_i;
      if (shift_i) acc_q <= {acc_q[WORD_W-BYTE_W-1:0], byte_i};
    end
  end

  always_comb begin
    case (fmt_i)
      FMT_W24:  load_word_o = acc_q;
      FMT_W16:  load_word_o = {8'h00, acc_q[15:0]};
      FMT_B_HI: load_word_o = {8'h00, acc_q[7:0], 8'h00};
      default:  load_word_o = {16'h0000, acc_q[7:0]};
    endcase
  end

  // right-align the store source, then pick byte counted from the top
  always_comb begin
    src = (fmt_i == FMT_B_HI) ? {8'h00, buf_q[WORD_W-1:BYTE_W]} : buf_q;
    sh  = bytes_per_word(fmt_i) - 2'd1 - idx_i;
    case (sh)
      2'd0:    store_byte_o = src[7:0];
      2'd1:    store_byte_o = src[15:8];
      default: store_byte_o = src[23:16];
    endcase
  end
endmodule

// File: rtl/bmd_seq.sv
module bmd_seq import bmd_pkg::*; #(
  parameter int IADDR_W = 14,
  parameter int CNT_W   = 14,
  parameter int WS_W    = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               iaddr_we_i,
  input  logic [IADDR_W-1:0] iaddr_i,
  input  logic               dir_i,
  input  fmt_e               fmt_i,
  input  logic [WS_W-1:0]    ws_i,
  input  logic               ext_req_i,
  output state_e             state_o,
  output logic [IADDR_W-1:0] iaddr_o,
  output logic [CNT_W-1:0]   count_o,
  output logic [1:0]         idx_o,
  output logic               byte_end_o,
  output logic               irq_o
);
  state_e            state_q, after_word;
  logic [WS_W-1:0]   wait_q;
  logic              last_byte, finish;

  assign state_o = state_q;

  always_comb begin
    byte_end_o = (state_q == ST_BYTE) && (wait_q == '0);
    last_byte  = (idx_o == bytes_per_word(fmt_i) - 2'd1);
    finish     = (state_q == ST_XFER) || (byte_end_o && last_byte && dir_i);
    if (count_o == CNT_W'(1)) after_word = ST_IDLE;
    else                      after_word = dir_i ? ST_FETCH : ST_ARB;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
      idx_o   <= '0;
      iaddr_o <= '0;
      count_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (iaddr_we_i) iaddr_o <= iaddr_i;
      if (finish) begin
        count_o <= count_o - 1'b1;
        iaddr_o <= iaddr_o + 1'b1;
        if (count_o == CNT_W'(1)) irq_o <= 1'b1;
      end
      case (state_q)
        ST_IDLE: if (start_i) begin
          count_o <= cnt_i;
          idx_o   <= '0;
          state_q <= dir_i ? ST_FETCH : ST_ARB;
        end
        ST_FETCH: state_q <= ST_ARB;
        ST_ARB: if (!ext_req_i) begin
          state_q <= ST_BYTE;
          wait_q  <= ws_i;
        end
        ST_BYTE: begin
          if (wait_q != '0) wait_q <= wait_q - 1'b1;
          else if (!last_byte) begin
            idx_o   <= idx_o + 1'b1;
            state_q <= ST_ARB;
          end else begin
            idx_o   <= '0;
            state_q <= dir_i ? after_word : ST_XFER;
          end
        end
        ST_XFER: state_q <= after_word;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bytemem_dma.sv
module bytemem_dma import bmd_pkg::*; #(
  parameter int ADDR_W  = 14,
  parameter int IADDR_W = 14,
  parameter int WS_W    = 3,
  localparam int CNT_W  = ADDR_W,
  localparam int CTRL_W = 3 + WS_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [2:0]         cfg_sel_i,
  input  logic [ADDR_W-1:0]  cfg_wdata_i,
  input  logic               ext_req_i,
  output logic               bm_sel_o,
  output logic               bm_rd_o,
  output logic               bm_wr_o,
  output logic [ADDR_W-1:0]  bm_addr_o,
  output logic [BUS_W-1:0]   bm_data_o,
  input  logic [BYTE_W-1:0]  bm_din_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic               mem_prog_o,
  output logic [IADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0]  mem_wdata_o,
  input  logic [WORD_W-1:0]  mem_rdata_i,
  output logic               busy_o,
  output logic [CNT_W-1:0]   word_count_o,
  output logic               irq_o
);
  logic               we_ok, start, dir;
  fmt_e               fmt;
  logic [WS_W-1:0]    ws;
  state_e             state;
  logic [IADDR_W-1:0] iaddr;
  logic [1:0]         idx;
  logic               byte_end, in_byte, fetch, xfer;
  logic [ADDR_W-1:0]  ofs;
  logic [PAGE_W-1:0]  page;
  logic [WORD_W-1:0]  load_word;
  logic [BYTE_W-1:0]  store_byte;

  assign busy_o  = (state != ST_IDLE);
  assign we_ok   = cfg_we_i && !busy_o;
  assign start   = we_ok && (cfg_sel_i == SEL_CNT) && (cfg_wdata_i != '0);
  assign in_byte = (state == ST_BYTE);
  assign fetch   = (state == ST_FETCH);
  assign xfer    = (state == ST_XFER);

  bmd_cfg_regs #(.WS_W(WS_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i    (we_ok && cfg_sel_i == SEL_CTRL),
    .wdata_i (cfg_wdata_i[CTRL_W-1:0]),
    .dir_o   (dir), .fmt_o (fmt), .ws_o (ws)
  );

  bmd_ext_addr #(.ADDR_W(ADDR_W)) u_ext (
    .clk_i, .rst_ni,
    .ofs_we_i  (we_ok && cfg_sel_i == SEL_EOFS),
    .page_we_i (we_ok && cfg_sel_i == SEL_PAGE),
    .wdata_i   (cfg_wdata_i),
    .inc_i     (byte_end),
    .ofs_o     (ofs), .page_o (page)
  );

  bmd_seq #(.IADDR_W(IADDR_W), .CNT_W(CNT_W), .WS_W(WS_W)) u_seq (
    .clk_i, .rst_ni,
    .start_i    (start),
    .cnt_i      (cfg_wdata_i[CNT_W-1:0]),
    .iaddr_we_i (we_ok && cfg_sel_i == SEL_IADDR),
    .iaddr_i    (cfg_wdata_i[IADDR_W-1:0]),
    .dir_i      (dir), .fmt_i (fmt), .ws_i (ws),
    .ext_req_i,
    .state_o    (state), .iaddr_o (iaddr), .count_o (word_count_o),
    .idx_o      (idx), .byte_end_o (byte_end), .irq_o
  );

  bmd_word_path u_path (
    .clk_i, .rst_ni,
    .fmt_i        (fmt),
    .cap_i        (fetch),
    .word_i       (mem_rdata_i),
    .shift_i      (byte_end && !dir),
    .byte_i       (bm_din_i),
    .idx_i        (idx),
    .load_word_o  (load_word),
    .store_byte_o (store_byte)
  );

  assign bm_sel_o    = in_byte;
  assign bm_rd_o     = in_byte && !dir;
  assign bm_wr_o     = in_byte && dir;
  assign bm_addr_o   = in_byte ? ofs : '0;
  assign bm_data_o   = in_byte ? {page, (dir ? store_byte : 8'h00), 8'h00} : '0;
  assign mem_req_o   = fetch || xfer;
  assign mem_we_o    = xfer;
  assign mem_prog_o  = (fetch || xfer) && (fmt == FMT_W24);
  assign mem_addr_o  = (fetch || xfer) ? iaddr : '0;
  assign mem_wdata_o = xfer ? load_word : '0;
endmodule

// File: rtl/bytemem_dma_chk.sv
module bytemem_dma_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ext_req_i,
  input logic              bm_sel_o,
  input logic              bm_rd_o,
  input logic              bm_wr_o,
  input logic [ADDR_W-1:0] bm_addr_o,
  input logic [23:0]       bm_data_o,
  input logic              mem_req_o,
  input logic              busy_o,
  input logic [ADDR_W-1:0] word_count_o,
  input logic              irq_o
);
  // R10
  ext_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bm_sel_o) |-> !$past(ext_req_i));
  // R9
  dir_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bm_rd_o, bm_wr_o}) && ((bm_rd_o || bm_wr_o) == bm_sel_o));
  // R7
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bm_sel_o && $past(bm_sel_o) |-> $stable(bm_addr_o) && $stable(bm_data_o[23:16]));
  // R8
  mem_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  // R11
  cnt_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> word_count_o <= $past(word_count_o));
  // R12
  irq_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (word_count_o == '0) && !busy_o);
  // R12
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

bind bytemem_dma bytemem_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .ext_req_i, .bm_sel_o, .bm_rd_o, .bm_wr_o, .bm_addr_o,
  .bm_data_o, .mem_req_o, .busy_o, .word_count_o, .irq_o
);

// File: tb/bytemem_dma_bench.sv
module bytemem_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [13:0] cfg_wdata;
  logic        ext_req;
  logic        bm_sel, bm_rd, bm_wr;
  logic [13:0] bm_addr;
  logic [23:0] bm_data;
  logic [7:0]  bm_din;
  logic        mem_req, mem_we, mem_prog;
  logic [13:0] mem_addr;
  logic [23:0] mem_wdata, mem_rdata;
  logic        busy, irq;
  logic [13:0] wcount;

  always #5 clk = ~clk;

  bytemem_dma u_bytemem_dma (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .ext_req_i(ext_req), .bm_sel_o(bm_sel),
    .bm_rd_o(bm_rd), .bm_wr_o(bm_wr), .bm_addr_o(bm_addr), .bm_data_o(bm_data),
    .bm_din_i(bm_din), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_prog_o(mem_prog), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .busy_o(busy), .word_count_o(wcount), .irq_o(irq)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, irq_cnt = 0, run_len = 0;
  logic [23:0] pmem [256];
  logic [23:0] dmem [256];
  int exp_baddr[$], exp_bbyte[$], exp_mwa[$], exp_mwd[$], exp_mra[$];
  logic cur_dir, cur_prog, sel_prev = 1'b0, hog_en = 1'b0;
  int   cur_ws;
  logic [7:0] lf = 8'h5B;

  function automatic logic [7:0] bytev(int a);
    return 8'((a * 13) ^ (a >> 8) ^ 32'hA5);
  endfunction

  assign bm_din    = bytev({10'd0, bm_data[23:16], bm_addr});
  assign mem_rdata = mem_prog ? pmem[mem_addr[7:0]] : dmem[mem_addr[7:0]];

  task automatic chk(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // per-cycle comparison against the expected access streams
  always @(negedge clk) begin
    if (rst_n) begin
      if (bm_sel && !sel_prev) begin
        chk("R10 access after free bus", int'(ext_req), 0);
        chk("R9 read strobe", int'(bm_rd), int'(!cur_dir));
        chk("R9 write strobe", int'(bm_wr), int'(cur_dir));
        if (exp_baddr.size() == 0) chk("R6 unexpected byte access", 1, 0);
        else chk("R6 byte address", {10'd0, bm_data[23:16], bm_addr}, exp_baddr.pop_front());
        if (cur_dir) begin
          if (exp_bbyte.size() == 0) chk("R9 unexpected store byte", 1, 0);
          else chk("R3/R4/R5 store byte", int'(bm_data[15:8]), exp_bbyte.pop_front());
        end
        run_len = 1;
      end else if (bm_sel) run_len++;
      if (!bm_sel && sel_prev) chk("R7 access length", run_len, cur_ws + 1);
      sel_prev = bm_sel;
      if (mem_req) begin
        chk("R3/R4 program space", int'(mem_prog), int'(cur_prog));
        if (mem_we) begin
          if (exp_mwa.size() == 0) chk("R8 unexpected write", 1, 0);
          else begin
            chk("R8 write address", int'(mem_addr), exp_mwa.pop_front());
            chk("R3/R4/R5 loaded word", int'(mem_wdata), exp_mwd.pop_front());
          end
        end else begin
          if (exp_mra.size() == 0) chk("R8 unexpected read", 1, 0);
          else chk("R8 read address", int'(mem_addr), exp_mra.pop_front());
        end
      end
      if (irq) begin
        irq_cnt++;
        chk("R12 count at irq", int'(wcount), 0);
        chk("R12 idle at irq", int'(busy), 0);
      end
    end
    lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    ext_req <= hog_en & lf[0];
  end

  task automatic wr(input logic [2:0] s, input int v);
    cfg_sel = s; cfg_wdata = v[13:0]; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(input logic dir, input int fmt, input int ws, input int ia,
                     input int ea, input int pg, input int n, input logic hog,
                     input logic poke);
    int a, nb, w;
    logic [7:0] b [3];
    a  = (pg << 14) | ea;
    nb = (fmt == 0) ? 3 : (fmt == 1) ? 2 : 1;
    for (int k = 0; k < n; k++) begin
      if (!dir) begin
        for (int j = 0; j < nb; j++) begin
          exp_baddr.push_back(a); b[j] = bytev(a); a = (a + 1) & 32'h3FFFFF;
        end
        case (fmt)
          0: w = {8'd0, b[0], b[1], b[2]};
          1: w = {16'd0, b[0], b[1]};
          2: w = {16'd0, b[0], 8'd0};
          default: w = {24'd0, b[0]};
        endcase
        exp_mwa.push_back(ia + k); exp_mwd.push_back(w);
      end else begin
        w = (fmt == 0) ? int'(pmem[(ia + k) & 255]) : int'(dmem[(ia + k) & 255]);
        exp_mra.push_back(ia + k);
        case (fmt)
          0: begin exp_bbyte.push_back((w >> 16) & 255); exp_bbyte.push_back((w >> 8) & 255);
                   exp_bbyte.push_back(w & 255); end
          1: begin exp_bbyte.push_back((w >> 8) & 255); exp_bbyte.push_back(w & 255); end
          2: exp_bbyte.push_back((w >> 8) & 255);
          default: exp_bbyte.push_back(w & 255);
        endcase
        for (int j = 0; j < nb; j++) begin
          exp_baddr.push_back(a); a = (a + 1) & 32'h3FFFFF;
        end
      end
    end
    cur_dir = dir; cur_prog = (fmt == 0); cur_ws = ws; irq_cnt = 0;
    wr(3'd0, ia); wr(3'd1, ea); wr(3'd2, pg);
    wr(3'd3, (ws << 3) | (fmt << 1) | int'(dir));
    hog_en = hog;
    wr(3'd4, n);
    chk("R2 start busy", int'(busy), 1);
    chk("R11 count loaded", int'(wcount), n);
    if (poke) begin
      // R13: reconfiguration attempts mid-transfer
      wr(3'd4, 9); wr(3'd2, 8'h33); wr(3'd1, 14'h0101);
      wr(3'd3, 6'b111111); wr(3'd0, 14'h0077);
      chk("R13 count not reloaded", int'(wcount <= 14'(n)), 1);
    end
    while (busy) @(negedge clk);
    hog_en = 1'b0;
    @(negedge clk);
    chk("R12 one pulse", irq_cnt, 1);
    chk("R11 count zero", int'(wcount), 0);
    chk("R6 byte stream consumed", exp_baddr.size(), 0);
    chk("R8 word stream consumed", exp_mwa.size() + exp_mra.size(), 0);
    exp_baddr.delete(); exp_bbyte.delete(); exp_mwa.delete();
    exp_mwd.delete(); exp_mra.delete();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d expected <100000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      pmem[i] = 24'(i * 32'h010203 ^ 32'h5A5A5A);
      dmem[i] = 24'(i * 32'h000707 + 32'h123456);
    end
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0; ext_req = 1'b0;
    cur_dir = 1'b0; cur_prog = 1'b1; cur_ws = 0;
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 bm_sel", int'(bm_sel), 0);
    chk("R1 mem_req", int'(mem_req), 0);
    chk("R1 count", int'(wcount), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: zero count does nothing
    irq_cnt = 0;
    wr(3'd4, 0);
    chk("R2 zero no start", int'(busy), 0);
    repeat (4) @(negedge clk);
    chk("R2 zero no irq", irq_cnt, 0);
    // R3 24-bit load across a page boundary (R6)
    run(1'b0, 0, 2, 10, 14'h3FFE, 5, 3, 1'b0, 1'b0);
    // R4 16-bit store under processor contention (R10)
    run(1'b1, 1, 0, 20, 14'h0100, 8'h12, 4, 1'b1, 1'b0);
    // R5 byte formats
    run(1'b0, 2, 1, 30, 14'h0040, 8'h01, 3, 1'b1, 1'b0);
    run(1'b0, 3, 0, 40, 14'h1234, 8'h7E, 2, 1'b0, 1'b0);
    run(1'b1, 2, 3, 50, 14'h0008, 8'h02, 2, 1'b0, 1'b0);
    // R6 whole-space wrap with LSB store
    run(1'b1, 3, 0, 60, 14'h3FFF, 8'hFF, 2, 1'b0, 1'b0);
    // R13 writes while busy are ignored
    run(1'b0, 1, 1, 70, 14'h0200, 8'h03, 3, 1'b0, 1'b1);
    // R3 24-bit store with contention
    run(1'b1, 0, 0, 80, 14'h3FFD, 8'h40, 2, 1'b1, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule